// File: doc/BRIEF.md
# Shifted Bit-Block Transfer Engine

This engine moves a rectangle of 16-bit words from a source bitmap to a destination bitmap. On the way it shifts the source right by a chosen number of bits and combines each shifted word with the destination word already in memory. Software loads the two start addresses, the rectangle size in words and scan lines, the two line pitches, a shift amount and a merge code, then pulses `start`. The engine walks the rectangle row by row through one request/ready memory port and pulses `done` when the last word of the last row is written.

Each output word is built from the current source word and the one read just before it in the same row, so bits shifted out of one word land in the next. The shift runs one bit per clock inside a 32-bit register while the destination read is still in flight. Read wait states therefore absorb shift cycles. Shift requests of 16 to 31 are folded into a one-word move of the source start plus a residual shift of 0 to 15.

Top module: `blit_engine`

## Requirements
- R1: `start` is taken only while `busy` is low. For a non-empty rectangle, `busy` is high from the cycle after `start` until the cycle in which `done` is high. `done` is high for one cycle, and `busy` is low in that cycle.
- R2: With residual shift r (0..15), output word k of a row equals the low 16 bits of ({P, S_k} >> r). Here S_k is source word k of that row, and P is source word k-1, or zero for the first word of each row.
- R3: Merge code `cfg_op` selects the word written: 0 writes the shifted source unchanged, 1 writes source OR destination, 2 writes source XOR destination, 3 writes source AND destination.
- R4: A shift request s of 16 or more (bit 4 set) acts as a residual shift of s-16, with the source start address lowered by one word.
- R5: Word k of row j is read at source base + j*src_pitch + k and written at `cfg_dst` + j*dst_pitch + k. No other address is written.
- R6: Each rectangle word takes exactly one source read, then one destination read, then one write. A rectangle of w by h words makes 2*w*h reads and w*h writes.
- R7: A request stays asserted with a stable address, direction and write data until `mem_ready` is seen. Results are correct for any number of wait states.
- R8: With w read wait states, the destination-read phase of a word lasts max(w+1, r) cycles. With no wait states, a shift of 9 costs 8 more cycles per word than a shift of 0. With 4 wait states, shifts of 0 and 5 take the same total time.
- R9: A rectangle with zero width or zero height gives `done` in the cycle after `start`, keeps `busy` low and makes no memory access.
- R10: During and after reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the cfg_* values |
| cfg_src | input | ADDR_W | Source start word address |
| cfg_dst | input | ADDR_W | Destination start word address |
| cfg_width | input | LEN_W | Words per row |
| cfg_height | input | LEN_W | Number of rows |
| cfg_shift | input | SH_W | Requested right shift, 0..31 |
| cfg_op | input | 2 | Merge code |
| cfg_src_pitch | input | ADDR_W | Source words per line |
| cfg_dst_pitch | input | ADDR_W | Destination words per line |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Six table rows pair each merge code with a different shift: zero, small, maximal residual, folded above 16, and exactly 16. The rows also vary pitches, shapes and wait counts from zero to four. A wrong carry between neighbouring words, a missing row-start clear or a wrong fold offset therefore shows up as a distinct memory image. Whole-memory comparison also exposes writes outside the rectangle. Paired timing runs separate the hidden shift (four waits, shifts 0 and 5) from the exposed one (no waits, shifts 0 and 9). Empty rectangles of either dimension check the immediate finish.

// File: rtl/blit_pkg.sv
package blit_pkg;
    typedef enum logic [1:0] {
        OP_COPY = 2'd0,
        OP_OR   = 2'd1,
        OP_XOR  = 2'd2,
        OP_AND  = 2'd3
    } blit_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SRC,
        ST_DST,
        ST_WR
    } blit_st_e;
endpackage

// File: rtl/blit_fold.sv
// Normalises a 0..31 shift request into a residual 0..15 shift and a source base.
module blit_fold #(
    parameter int ADDR_W = 16,
    parameter int SH_W   = 5,
    localparam int RES_W = SH_W - 1
) (
    input  logic [SH_W-1:0]   shift_req,
    input  logic [ADDR_W-1:0] src_in,
    output logic [RES_W-1:0]  res_shift,
    output logic [ADDR_W-1:0] src_base
);
    logic over;

    always_comb begin
        over      = shift_req[SH_W-1];
        res_shift = shift_req[RES_W-1:0];
        src_base  = over ? (src_in - ADDR_W'(1)) : src_in;
    end
endmodule

// File: rtl/blit_merge.sv
// Combines the aligned source word with the fetched destination word.
module blit_merge #(
    parameter int DW = 16
) (
    input  blit_pkg::blit_op_e op,
    input  logic [DW-1:0]      src,
    input  logic [DW-1:0]      dst,
    output logic [DW-1:0]      result
);
    import blit_pkg::*;

    always_comb begin
        unique case (op)
            OP_COPY: result = src;
            OP_OR:   result = src | dst;
            OP_XOR:  result = src ^ dst;
            OP_AND:  result = src & dst;
            default: result = src;
        endcase
    end
endmodule

// File: rtl/blit_engine.sv
module blit_engine #(
    parameter int DW     = 16,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    localparam int RES_W = $clog2(DW),
    localparam int SH_W  = RES_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [LEN_W-1:0]  cfg_width,
    input  logic [LEN_W-1:0]  cfg_height,
    input  logic [SH_W-1:0]   cfg_shift,
    input  logic [1:0]        cfg_op,
    input  logic [ADDR_W-1:0] cfg_src_pitch,
    input  logic [ADDR_W-1:0] cfg_dst_pitch,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done
);
    import blit_pkg::*;

    typedef struct packed {
        blit_st_e          st;
        logic [LEN_W-1:0]  col;
        logic [LEN_W-1:0]  row;
        logic [LEN_W-1:0]  width;
        logic [LEN_W-1:0]  height;
        logic [ADDR_W-1:0] src_row;
        logic [ADDR_W-1:0] dst_row;
        logic [ADDR_W-1:0] src_pitch;
        logic [ADDR_W-1:0] dst_pitch;
        logic [DW-1:0]     prev;
        logic [DW-1:0]     dst_data;
        logic [2*DW-1:0]   sh;
        logic [RES_W-1:0]  cnt;
        logic [RES_W-1:0]  res;
        blit_op_e          op;
        logic              dst_got;
        logic              done;
    } state_t;

    state_t s_q, s_d;

    logic [RES_W-1:0]  fold_res;
    logic [ADDR_W-1:0] fold_src;
    logic [DW-1:0]     merged;
    logic              row_last_d;

    blit_fold #(.ADDR_W(ADDR_W), .SH_W(SH_W)) fold_i (
        .shift_req (cfg_shift),
        .src_in    (cfg_src),
        .res_shift (fold_res),
        .src_base  (fold_src)
    );

    blit_merge #(.DW(DW)) merge_i (
        .op     (s_q.op),
        .src    (s_q.sh[DW-1:0]),
        .dst    (s_q.dst_data),
        .result (merged)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = s_q.dst_row + ADDR_W'(s_q.col);
        row_last_d = (s_q.col == s_q.width - LEN_W'(1));
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.width     = cfg_width;
                    s_d.height    = cfg_height;
                    s_d.src_pitch = cfg_src_pitch;
                    s_d.dst_pitch = cfg_dst_pitch;
                    s_d.op        = blit_op_e'(cfg_op);
                    s_d.res       = fold_res;
                    s_d.src_row   = fold_src;
                    s_d.dst_row   = cfg_dst;
                    s_d.col       = '0;
                    s_d.row       = '0;
                    s_d.prev      = '0;
                    if (cfg_width == '0 || cfg_height == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = ST_SRC;
                    end
                end
            end
            ST_SRC: begin
                mem_req  = 1'b1;
                mem_addr = s_q.src_row + ADDR_W'(s_q.col);
                if (mem_ready) begin
                    s_d.sh      = {s_q.prev, mem_rdata};
                    s_d.prev    = mem_rdata;
                    s_d.cnt     = s_q.res;
                    s_d.dst_got = 1'b0;
                    s_d.st      = ST_DST;
                end
            end
            ST_DST: begin
                mem_req = !s_q.dst_got;
                if (!s_q.dst_got && mem_ready) begin
                    s_d.dst_data = mem_rdata;
                    s_d.dst_got  = 1'b1;
                end
                if (s_q.cnt != '0) begin
                    s_d.sh  = s_q.sh >> 1;
                    s_d.cnt = s_q.cnt - RES_W'(1);
                end
                if (s_d.dst_got && s_d.cnt == '0) begin
                    s_d.st = ST_WR;
                end
            end
            ST_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    s_d.st = ST_SRC;
                    if (row_last_d) begin
                        s_d.col  = '0;
                        s_d.prev = '0;
                        if (s_q.row == s_q.height - LEN_W'(1)) begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.row     = s_q.row + LEN_W'(1);
                            s_d.src_row = s_q.src_row + s_q.src_pitch;
                            s_d.dst_row = s_q.dst_row + s_q.dst_pitch;
                        end
                    end else begin
                        s_d.col = s_q.col + LEN_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_wdata = merged;
    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
    parameter int DW     = 16,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  cfg_width,
    input logic [LEN_W-1:0]  cfg_height,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic              mem_ready,
    input logic              busy,
    input logic              done
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R7
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_ready |=> $stable(mem_wdata)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done || $past(start)); // R1
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && cfg_width != '0 && cfg_height != '0 |=> busy); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R9
    AST_EMPTY_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (cfg_width == '0 || cfg_height == '0) |=> done && !busy); // R9
endmodule

bind blit_engine blit_engine_chk #(.DW(DW), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/blit_engine_tb_top.sv
`timescale 1ns/1ps
module blit_engine_tb_top;
    typedef struct packed {
        logic [7:0] src;
        logic [7:0] dst;
        logic [7:0] w;
        logic [7:0] h;
        logic [4:0] sh;
        logic [1:0] op;
        logic [7:0] sp;
        logic [7:0] dp;
        logic [2:0] wt;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{src:8'd10, dst:8'd100, w:8'd3, h:8'd2, sh:5'd0,  op:2'd0, sp:8'd8, dp:8'd8,  wt:3'd0},
        '{src:8'd20, dst:8'd130, w:8'd4, h:8'd3, sh:5'd5,  op:2'd1, sp:8'd6, dp:8'd10, wt:3'd1},
        '{src:8'd40, dst:8'd170, w:8'd2, h:8'd2, sh:5'd15, op:2'd2, sp:8'd4, dp:8'd5,  wt:3'd3},
        '{src:8'd50, dst:8'd190, w:8'd3, h:8'd1, sh:5'd20, op:2'd3, sp:8'd3, dp:8'd3,  wt:3'd2},
        '{src:8'd60, dst:8'd200, w:8'd5, h:8'd2, sh:5'd9,  op:2'd0, sp:8'd7, dp:8'd7,  wt:3'd4},
        '{src:8'd70, dst:8'd220, w:8'd1, h:8'd3, sh:5'd16, op:2'd1, sp:8'd2, dp:8'd4,  wt:3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_src_pitch = '0, cfg_dst_pitch = '0;
    logic [7:0]  cfg_width = '0, cfg_height = '0;
    logic [4:0]  cfg_shift = '0;
    logic [1:0]  cfg_op = '0;
    logic        mem_req, mem_we, mem_ready, busy, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];
    int          wcnt = 0;
    int          wait_n = 0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    blit_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_shift(cfg_shift), .cfg_op(cfg_op), .cfg_src_pitch(cfg_src_pitch),
        .cfg_dst_pitch(cfg_dst_pitch), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done)
    );

    assign mem_ready = mem_req && (wcnt == wait_n);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            wcnt <= 0;
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end else if (mem_req) begin
            wcnt <= wcnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 16'((i * 40503 + seed * 977) ^ (i << 9) ^ 16'h3c5a);
            exp_mem[i] = mem[i];
        end
    endtask

    // Reference per R2..R5: sequential word order, shared address space.
    task automatic model(input vec_t v);
        int base = (v.sh >= 16) ? int'(v.src) - 1 : int'(v.src);
        int r    = int'(v.sh) % 16;
        for (int j = 0; j < int'(v.h); j++) begin
            logic [15:0] prev = '0;
            for (int k = 0; k < int'(v.w); k++) begin
                int          sa  = (base + j * int'(v.sp) + k) & 255;
                int          da  = (int'(v.dst) + j * int'(v.dp) + k) & 255;
                logic [15:0] cur = exp_mem[sa];
                logic [31:0] t   = {prev, cur} >> r;
                logic [15:0] d   = exp_mem[da];
                logic [15:0] res;
                case (v.op)
                    2'd1:    res = t[15:0] | d;
                    2'd2:    res = t[15:0] ^ d;
                    2'd3:    res = t[15:0] & d;
                    default: res = t[15:0];
                endcase
                exp_mem[da] = res;
                prev = cur;
            end
        end
    endtask

    task automatic run(input vec_t v, output int cyc);
        @(negedge clk);
        wait_n        = int'(v.wt);
        cfg_src       = 16'(v.src);
        cfg_dst       = 16'(v.dst);
        cfg_width     = v.w;
        cfg_height    = v.h;
        cfg_shift     = v.sh;
        cfg_op        = v.op;
        cfg_src_pitch = 16'(v.sp);
        cfg_dst_pitch = 16'(v.dp);
        start         = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        if (v.w != 0 && v.h != 0) begin
            check(busy === 1'b1, "R1", "busy after start", longint'(busy), 1);
            while (done !== 1'b1) begin
                @(negedge clk);
                cyc++;
            end
            check(busy === 1'b0, "R1", "busy with done", longint'(busy), 0);
            @(negedge clk);
            check(done === 1'b0, "R1", "done pulse width", longint'(done), 0);
        end
    endtask

    task automatic mem_check(input string req, input string what);
        int bad = -1;
        for (int i = 0; i < 256; i++) begin
            if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        end
        if (bad < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, what, longint'(mem[bad]), longint'(exp_mem[bad]));
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL R1 watchdog expired: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int   cyc, wr0, rd0, c_a, c_b;
        vec_t t;
        fill(1);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R10", "reset outputs",
              longint'({busy, done, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R10", "after reset",
              longint'({busy, done, mem_req}), 0);

        // Table: R2 shifts, R3 ops, R4 fold, R5 addressing, R7 waits, R6 counts
        for (int n = 0; n < NV; n++) begin
            fill(n + 2);
            model(VECS[n]);
            wr0 = wr_cnt;
            rd0 = rd_cnt;
            run(VECS[n], cyc);
            mem_check("R2 R3 R4 R5 R7", $sformatf("memory image vector %0d", n));
            check(wr_cnt - wr0 == int'(VECS[n].w) * int'(VECS[n].h), "R6", "write count",
                  wr_cnt - wr0, int'(VECS[n].w) * int'(VECS[n].h));
            check(rd_cnt - rd0 == 2 * int'(VECS[n].w) * int'(VECS[n].h), "R6", "read count",
                  rd_cnt - rd0, 2 * int'(VECS[n].w) * int'(VECS[n].h));
        end

        // R9: zero width, then zero height
        for (int z = 0; z < 2; z++) begin
            fill(20 + z);
            t = VECS[1];
            if (z == 0) t.w = 8'd0; else t.h = 8'd0;
            wr0 = wr_cnt;
            rd0 = rd_cnt;
            run(t, cyc);
            check(done === 1'b1 && busy === 1'b0, "R9", "empty finish next cycle",
                  longint'({done, busy}), 2);
            @(negedge clk);
            check(wr_cnt == wr0 && rd_cnt == rd0, "R9", "no access on empty",
                  (wr_cnt - wr0) + (rd_cnt - rd0), 0);
            mem_check("R9", "memory untouched");
        end

        // R8: exposed shift with no waits
        t = VECS[0];
        t.wt = 3'd0; t.sh = 5'd0;
        run(t, c_a);
        t.sh = 5'd9;
        run(t, c_b);
        check(c_b - c_a == 8 * int'(t.w) * int'(t.h), "R8", "exposed shift cost",
              c_b - c_a, 8 * int'(t.w) * int'(t.h));
        // R8: hidden shift with four waits
        t.wt = 3'd4; t.sh = 5'd0;
        run(t, c_a);
        t.sh = 5'd5;
        run(t, c_b);
        check(c_a == c_b, "R8", "hidden shift cost", c_b, c_a);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule